// File: doc/BRIEF.md
# Accumulator ALU with Selective Flag Update

This block is the arithmetic and logic core for a small accumulator-style processor with 8-bit data. It is purely combinational. Each cycle it takes an operation code, a register operand (accumulator, X, Y, or a memory byte routed there for read-modify-write), a second operand from memory, and the current status flags. It returns the new data value, the new N, V, Z and C flags, and a write enable for each flag. Surrounding register logic then commits only the flags that the operation is defined to change.

Add and subtract use the carry flag as the inbound carry. For subtraction the carry means "no borrow". Compare and bit test set flags and never write a data result. When decimal arithmetic is allowed, a set D flag turns add and subtract into packed-BCD arithmetic. The `HAS_DECIMAL` parameter can remove the BCD path entirely. When it is removed, or when the `dec_allow` input is low, arithmetic stays binary whatever D holds.

Top module: `alu8_flags`

## Requirements
- R1: Opcode encoding: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left, 6 logical shift right, 7 rotate left, 8 rotate right, 9 increment, 10 decrement, 11 compare, 12 bit test. Flag bits, on both the flag bus and the enable bus, are N=bit 3, V=bit 2, Z=bit 1, C=bit 0. Binary add returns reg_a + mem_b + C modulo 256, sets C to the carry out, and enables all four flags.
- R2: Binary subtract returns reg_a - mem_b - (1 - C) modulo 256. It sets C to 1 when no borrow occurred and enables all four flags.
- R3: For add and subtract, V is set exactly when the two addends (mem_b inverted for subtract) share a sign bit and the sum's sign bit differs from it.
- R4: AND, OR and XOR return the bitwise result and enable only N and Z.
- R5: Shift left moves bit 7 into C and fills bit 0 with 0. Logical shift right moves bit 0 into C and fills bit 7 with 0. Rotate left fills bit 0 with the old C, and rotate right fills bit 7 with the old C. All four act on reg_a and enable N, Z and C.
- R6: Increment and decrement act on reg_a, wrap modulo 256, and enable only N and Z.
- R7: Compare forms reg_a - mem_b. It sets C when reg_a >= mem_b (unsigned), sets Z when the operands are equal, and sets N from bit 7 of the difference. It enables N, Z and C, and res_wr is 0.
- R8: Bit test sets Z when (reg_a AND mem_b) is zero, N to mem_b bit 7, and V to mem_b bit 6. It enables N, V and Z, and res_wr is 0.
- R9: With D set and dec_allow high, add treats both operands as two packed BCD digits. It returns the BCD sum modulo 100, and C is the decimal carry out.
- R10: With D set and dec_allow high, subtract returns the BCD difference modulo 100. C is 0 exactly when a decimal borrow occurred.
- R11: With dec_allow low, add and subtract give the binary results of R1 and R2 whatever the D input holds.
- R12: For every opcode that writes a result, Z is set when the 8-bit result is zero and N equals result bit 7. res_wr is 1 for opcodes 0 to 10.
- R13: Opcodes 13 to 15 enable no flag and write no result.
- R14: Every flag whose enable is 0 is presented on flags_out with its incoming value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (see R1) |
| reg_a | input | 8 | Register operand; the operand of unary operations |
| mem_b | input | 8 | Memory operand |
| flags_in | input | 4 | Current N, V, Z, C flags |
| dec_mode | input | 1 | Current D flag |
| dec_allow | input | 1 | Configuration: decimal arithmetic permitted |
| result | output | 8 | Data result; meaningful only when res_wr is 1 |
| res_wr | output | 1 | Result is to be written back |
| flags_out | output | 4 | Next N, V, Z, C |
| flags_we | output | 4 | Per-flag write enables |

## Verification
The hardest region to reach is the decimal carry and borrow chain. A digit must overflow past 9, or underflow below 0, and the correction must ripple into the upper digit and then out as C. Random bytes rarely form valid BCD with that property. The stimulus therefore uses handpicked packed-BCD pairs whose low-digit sum is exactly 10 or greater, or whose low-digit difference is negative. It runs them with both carry-in values. The same byte pairs are repeated with dec_allow low to show the binary fallback. A sweep of pseudo-random binary operations covers the remaining flag masks.

// File: rtl/alu8_pkg.sv
`timescale 1ns/100ps
package alu8_pkg;

    localparam int FLG_N = 3;
    localparam int FLG_V = 2;
    localparam int FLG_Z = 1;
    localparam int FLG_C = 0;
    localparam int NFLAGS = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_CMP  = 4'd11,
        OP_BIT  = 4'd12,
        OP_R13  = 4'd13,
        OP_R14  = 4'd14,
        OP_R15  = 4'd15
    } alu_op_e;

    // write-enable masks, bit order N V Z C
    localparam logic [NFLAGS-1:0] MASK_ALL  = 4'b1111;
    localparam logic [NFLAGS-1:0] MASK_NZ   = 4'b1010;
    localparam logic [NFLAGS-1:0] MASK_NZC  = 4'b1011;
    localparam logic [NFLAGS-1:0] MASK_NVZ  = 4'b1110;
    localparam logic [NFLAGS-1:0] MASK_NONE = 4'b0000;

endpackage

// File: rtl/alu8_flag_mask.sv
`timescale 1ns/100ps
module alu8_flag_mask
    import alu8_pkg::*;
(
    input  alu_op_e              op,
    output logic [NFLAGS-1:0]    we,
    output logic                 wr
);
    always_comb begin
        we = MASK_NONE;
        wr = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                we = MASK_ALL;
                wr = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                we = MASK_NZ;
                wr = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                we = MASK_NZC;
                wr = 1'b1;
            end
            OP_CMP: we = MASK_NZC;
            OP_BIT: we = MASK_NVZ;
            default: begin
                we = MASK_NONE;
                wr = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_addsub.sv
`timescale 1ns/100ps
module alu8_addsub #(
    parameter int W           = 8,
    parameter bit HAS_DECIMAL = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    input  logic         dec,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int NIB = W / 4;

    logic [W-1:0] bx;
    logic [W:0]   bin_full;

    always_comb begin
        bx       = sub ? ~b : b;
        bin_full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
        ovf      = (a[W-1] == bx[W-1]) && (bin_full[W-1] != a[W-1]);
    end

    generate
        if (HAS_DECIMAL) begin : g_bcd
            logic [W-1:0] dsum;
            logic         dcout;

            always_comb begin
                logic       chain;
                logic [4:0] t5;
                logic [3:0] ad;
                logic [3:0] bd;
                // add: chain is a carry; subtract: chain is a borrow
                chain = sub ? ~cin : cin;
                dsum  = '0;
                for (int g = 0; g < NIB; g++) begin
                    ad = a[g*4 +: 4];
                    bd = b[g*4 +: 4];
                    if (!sub) begin
                        t5 = {1'b0, ad} + {1'b0, bd} + {4'b0, chain};
                        if (t5 > 5'd9) begin
                            t5    = t5 + 5'd6;
                            chain = 1'b1;
                        end else begin
                            chain = 1'b0;
                        end
                        dsum[g*4 +: 4] = t5[3:0];
                    end else begin
                        t5 = {1'b0, ad} - {1'b0, bd} - {4'b0, chain};
                        if (t5[4]) begin
                            dsum[g*4 +: 4] = t5[3:0] - 4'd6;
                            chain          = 1'b1;
                        end else begin
                            dsum[g*4 +: 4] = t5[3:0];
                            chain          = 1'b0;
                        end
                    end
                end
                dcout = sub ? ~chain : chain;
            end

            assign sum  = dec ? dsum  : bin_full[W-1:0];
            assign cout = dec ? dcout : bin_full[W];
        end else begin : g_bin
            logic unused_dec;
            assign unused_dec = dec;
            assign sum  = bin_full[W-1:0];
            assign cout = bin_full[W];
        end
    endgenerate
endmodule

// File: rtl/alu8_unary.sv
`timescale 1ns/100ps
module alu8_unary
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    always_comb begin
        res  = '0;
        cout = cin;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHL: begin
                res  = {a[W-2:0], 1'b0};
                cout = a[W-1];
            end
            OP_SHR: begin
                res  = {1'b0, a[W-1:1]};
                cout = a[0];
            end
            OP_ROL: begin
                res  = {a[W-2:0], cin};
                cout = a[W-1];
            end
            OP_ROR: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            OP_INC: res = a + {{(W-1){1'b0}}, 1'b1};
            OP_DEC: res = a - {{(W-1){1'b0}}, 1'b1};
            default: begin
                res  = '0;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/100ps
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W           = 8,
    parameter bit HAS_DECIMAL = 1'b1
) (
    input  logic [3:0]        op,
    input  logic [W-1:0]      reg_a,
    input  logic [W-1:0]      mem_b,
    input  logic [NFLAGS-1:0] flags_in,
    input  logic              dec_mode,
    input  logic              dec_allow,
    output logic [W-1:0]      result,
    output logic              res_wr,
    output logic [NFLAGS-1:0] flags_out,
    output logic [NFLAGS-1:0] flags_we
);
    typedef struct packed {
        logic [W-1:0]      res;
        logic              wr;
        logic [NFLAGS-1:0] flg;
        logic [NFLAGS-1:0] we;
    } alu_out_t;

    alu_op_e           op_e;
    logic              as_sub;
    logic              as_cin;
    logic              as_dec;
    logic [W-1:0]      as_sum;
    logic              as_cout;
    logic              as_ovf;
    logic [W-1:0]      un_res;
    logic              un_cout;
    logic [NFLAGS-1:0] mask_we;
    logic              mask_wr;
    alu_out_t          out_d;

    assign op_e   = alu_op_e'(op);
    assign as_sub = (op_e == OP_SUB) || (op_e == OP_CMP);
    assign as_cin = (op_e == OP_CMP) ? 1'b1 : flags_in[FLG_C];
    assign as_dec = dec_allow && dec_mode && (op_e != OP_CMP);

    alu8_addsub #(.W(W), .HAS_DECIMAL(HAS_DECIMAL)) i_addsub (
        .a    (reg_a),
        .b    (mem_b),
        .sub  (as_sub),
        .cin  (as_cin),
        .dec  (as_dec),
        .sum  (as_sum),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    alu8_unary #(.W(W)) i_unary (
        .op   (op_e),
        .a    (reg_a),
        .b    (mem_b),
        .cin  (flags_in[FLG_C]),
        .res  (un_res),
        .cout (un_cout)
    );

    alu8_flag_mask i_mask (
        .op (op_e),
        .we (mask_we),
        .wr (mask_wr)
    );

    always_comb begin
        logic [NFLAGS-1:0] raw;
        logic              arith;
        arith = (op_e == OP_ADD) || (op_e == OP_SUB) || (op_e == OP_CMP);

        out_d.res = arith ? as_sum : un_res;
        out_d.wr  = mask_wr;
        out_d.we  = mask_we;

        raw        = flags_in;
        raw[FLG_N] = out_d.res[W-1];
        raw[FLG_Z] = (out_d.res == '0);
        raw[FLG_V] = as_ovf;
        raw[FLG_C] = arith ? as_cout : un_cout;
        if (op_e == OP_BIT) begin
            raw[FLG_N] = mem_b[W-1];
            raw[FLG_V] = mem_b[W-2];
            raw[FLG_Z] = ((reg_a & mem_b) == '0);
        end

        for (int f = 0; f < NFLAGS; f++) begin
            out_d.flg[f] = out_d.we[f] ? raw[f] : flags_in[f];
        end
    end

    assign result    = out_d.res;
    assign res_wr    = out_d.wr;
    assign flags_out = out_d.flg;
    assign flags_we  = out_d.we;
endmodule

// File: rtl/alu8_flags_chk.sv
`timescale 1ns/100ps
module alu8_flags_chk #(
    parameter int W = 8
) (
    input logic [3:0]   op,
    input logic [W-1:0] reg_a,
    input logic [W-1:0] mem_b,
    input logic [3:0]   flags_in,
    input logic         dec_mode,
    input logic         dec_allow,
    input logic [W-1:0] result,
    input logic         res_wr,
    input logic [3:0]   flags_out,
    input logic [3:0]   flags_we
);
    logic [W-1:0] ref_add;
    assign ref_add = reg_a + mem_b + {{(W-1){1'b0}}, flags_in[0]};

    always_comb begin
        // R4
        if (op == 4'd2 || op == 4'd3 || op == 4'd4)
            a_r4_logic_keeps_cv: assert (!flags_we[2] && !flags_we[0]);
        // R7
        if (op == 4'd11)
            a_r7_cmp_no_write: assert (!res_wr);
        // R8
        if (op == 4'd12)
            a_r8_bit_copies_nv: assert (flags_out[3] == mem_b[W-1] && flags_out[2] == mem_b[W-2] && !res_wr);
        // R11
        if (op == 4'd0 && !(dec_allow && dec_mode))
            a_r11_binary_add: assert (result == ref_add);
        // R13
        if (op >= 4'd13)
            a_r13_reserved_inert: assert (!res_wr && flags_we == 4'b0000);
        // R5
        if (op == 4'd7)
            a_r5_rol_fills_carry: assert (result[0] == flags_in[0]);
        // R12
        if (res_wr)
            a_r12_zero_flag: assert (flags_out[1] == (result == '0) && flags_out[3] == result[W-1]);
        // R14
        for (int f = 0; f < 4; f++) begin
            if (!flags_we[f])
                a_r14_passthrough: assert (flags_out[f] == flags_in[f]);
        end
    end
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) i_chk (
    .op        (op),
    .reg_a     (reg_a),
    .mem_b     (mem_b),
    .flags_in  (flags_in),
    .dec_mode  (dec_mode),
    .dec_allow (dec_allow),
    .result    (result),
    .res_wr    (res_wr),
    .flags_out (flags_out),
    .flags_we  (flags_we)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/100ps
module test_alu8_flags;

    typedef struct {
        string      tag;
        logic [3:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [3:0] fin;
        logic [7:0] res;
        logic       wr;
        logic [3:0] flg;
        logic [3:0] we;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op = 4'd15;
    logic [7:0] reg_a = 8'h00;
    logic [7:0] mem_b = 8'h00;
    logic [3:0] flags_in = 4'b0000;
    logic       dec_mode = 1'b0;
    logic       dec_allow = 1'b0;
    logic [7:0] result;
    logic       res_wr;
    logic [3:0] flags_out;
    logic [3:0] flags_we;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    alu8_flags i_alu8_flags (
        .op        (op),
        .reg_a     (reg_a),
        .mem_b     (mem_b),
        .flags_in  (flags_in),
        .dec_mode  (dec_mode),
        .dec_allow (dec_allow),
        .result    (result),
        .res_wr    (res_wr),
        .flags_out (flags_out),
        .flags_we  (flags_we)
    );

    function automatic int bcd_val(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        logic [7:0] r;
        r[7:4] = 4'(v / 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    // reference model written from the requirements
    function automatic exp_t model(input string tag, input logic [3:0] o, input logic [7:0] a,
                                   input logic [7:0] b, input logic [3:0] fin,
                                   input logic d, input logic da);
        exp_t e;
        logic [3:0] nf;
        logic [8:0] s9;
        logic [7:0] bx;
        logic       c;
        int         dv;
        e.tag = tag; e.op = o; e.a = a; e.b = b; e.fin = fin;
        c  = fin[0];
        nf = fin;
        e.res = 8'h00;
        e.wr  = (o <= 4'd10);
        case (o)
            4'd0, 4'd1: begin
                bx = (o == 4'd1) ? ~b : b;
                s9 = {1'b0, a} + {1'b0, bx} + {8'b0, c};
                e.res = s9[7:0];
                nf[0] = s9[8];
                nf[2] = (a[7] == bx[7]) && (s9[7] != a[7]);
                if (d && da) begin
                    if (o == 4'd0) begin
                        dv = bcd_val(a) + bcd_val(b) + int'(c);
                        nf[0] = (dv >= 100);
                        e.res = to_bcd(dv % 100);
                    end else begin
                        dv = bcd_val(a) - bcd_val(b) - (1 - int'(c));
                        nf[0] = (dv >= 0);
                        e.res = to_bcd(dv < 0 ? dv + 100 : dv);
                    end
                end
                e.we = 4'b1111;
            end
            4'd2: begin e.res = a & b; e.we = 4'b1010; end
            4'd3: begin e.res = a | b; e.we = 4'b1010; end
            4'd4: begin e.res = a ^ b; e.we = 4'b1010; end
            4'd5: begin e.res = a << 1; nf[0] = a[7]; e.we = 4'b1011; end
            4'd6: begin e.res = a >> 1; nf[0] = a[0]; e.we = 4'b1011; end
            4'd7: begin e.res = {a[6:0], c}; nf[0] = a[7]; e.we = 4'b1011; end
            4'd8: begin e.res = {c, a[7:1]}; nf[0] = a[0]; e.we = 4'b1011; end
            4'd9: begin e.res = a + 8'd1; e.we = 4'b1010; end
            4'd10: begin e.res = a - 8'd1; e.we = 4'b1010; end
            4'd11: begin
                s9 = {1'b0, a} - {1'b0, b};
                nf[3] = s9[7];
                nf[1] = (a == b);
                nf[0] = (a >= b);
                e.we = 4'b1011;
            end
            4'd12: begin
                nf[3] = b[7];
                nf[2] = b[6];
                nf[1] = ((a & b) == 8'h00);
                e.we = 4'b1110;
            end
            default: e.we = 4'b0000;
        endcase
        if (e.wr) begin
            nf[3] = e.res[7];
            nf[1] = (e.res == 8'h00);
        end
        e.flg = nf;
        return e;
    endfunction

    task automatic apply(input string tag, input logic [3:0] o, input logic [7:0] a,
                         input logic [7:0] b, input logic [3:0] fin,
                         input logic d, input logic da);
        @(negedge clk);
        op = o; reg_a = a; mem_b = b; flags_in = fin; dec_mode = d; dec_allow = da;
        sb.push_back(model(tag, o, a, b, fin, d, da));
    endtask

    // monitor: compare at the rising edge, inputs were set at the falling edge
    always @(posedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if ((e.wr && result !== e.res) || res_wr !== e.wr ||
                flags_out !== e.flg || flags_we !== e.we) begin
                n_bad++;
                $display("FAIL %s op=%0d a=%02h b=%02h fin=%04b: got res=%02h wr=%0b flg=%04b we=%04b, expected res=%02h wr=%0b flg=%04b we=%04b",
                         e.tag, e.op, e.a, e.b, e.fin, result, res_wr, flags_out, flags_we,
                         e.res, e.wr, e.flg, e.we);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // initial state: reserved opcode idle (R13)
        apply("R13", 4'd15, 8'h00, 8'h00, 4'b0000, 1'b0, 1'b0);
        apply("R13", 4'd13, 8'h12, 8'h34, 4'b1111, 1'b1, 1'b1);
        apply("R13", 4'd14, 8'hFF, 8'h01, 4'b0101, 1'b0, 1'b1);
        // R1 binary add
        apply("R1", 4'd0, 8'h10, 8'h22, 4'b0000, 1'b0, 1'b1);
        apply("R1", 4'd0, 8'hFF, 8'h01, 4'b0000, 1'b0, 1'b1);
        apply("R1", 4'd0, 8'hFE, 8'h01, 4'b0001, 1'b0, 1'b0);
        // R2 subtract, C = no borrow
        apply("R2", 4'd1, 8'h50, 8'h20, 4'b0001, 1'b0, 1'b1);
        apply("R2", 4'd1, 8'h50, 8'h20, 4'b0000, 1'b0, 1'b1);
        apply("R2", 4'd1, 8'h00, 8'h01, 4'b0001, 1'b0, 1'b1);
        // R3 overflow
        apply("R3", 4'd0, 8'h50, 8'h50, 4'b0000, 1'b0, 1'b1);
        apply("R3", 4'd0, 8'h80, 8'hFF, 4'b0000, 1'b0, 1'b1);
        apply("R3", 4'd1, 8'h50, 8'hB0, 4'b0001, 1'b0, 1'b1);
        apply("R3", 4'd1, 8'h80, 8'h01, 4'b0001, 1'b0, 1'b1);
        // R4 logic ops keep V and C (R14 pass-through too)
        apply("R4", 4'd2, 8'hF0, 8'h0F, 4'b0101, 1'b0, 1'b0);
        apply("R4", 4'd3, 8'h80, 8'h01, 4'b0100, 1'b0, 1'b0);
        apply("R4", 4'd4, 8'hAA, 8'hAA, 4'b0001, 1'b0, 1'b0);
        // R5 shifts and rotates
        apply("R5", 4'd5, 8'h81, 8'h00, 4'b0000, 1'b0, 1'b0);
        apply("R5", 4'd6, 8'h01, 8'h00, 4'b0000, 1'b0, 1'b0);
        apply("R5", 4'd7, 8'h40, 8'h00, 4'b0001, 1'b0, 1'b0);
        apply("R5", 4'd8, 8'h02, 8'h00, 4'b0001, 1'b0, 1'b0);
        apply("R5", 4'd8, 8'h01, 8'h00, 4'b0000, 1'b0, 1'b0);
        // R6 increment / decrement wrap
        apply("R6", 4'd9, 8'hFF, 8'h00, 4'b0101, 1'b0, 1'b0);
        apply("R6", 4'd10, 8'h00, 8'h00, 4'b0000, 1'b0, 1'b0);
        apply("R6", 4'd9, 8'h7F, 8'h00, 4'b0000, 1'b0, 1'b0);
        // R7 compare, binary even in decimal mode
        apply("R7", 4'd11, 8'h40, 8'h40, 4'b0100, 1'b1, 1'b1);
        apply("R7", 4'd11, 8'h10, 8'h20, 4'b0001, 1'b0, 1'b0);
        apply("R7", 4'd11, 8'hF0, 8'h01, 4'b0000, 1'b0, 1'b0);
        // R8 bit test
        apply("R8", 4'd12, 8'h01, 8'hC0, 4'b0001, 1'b0, 1'b0);
        apply("R8", 4'd12, 8'h41, 8'h41, 4'b1100, 1'b0, 1'b0);
        // R9 decimal add
        apply("R9", 4'd0, 8'h58, 8'h46, 4'b0001, 1'b1, 1'b1);
        apply("R9", 4'd0, 8'h15, 8'h26, 4'b0000, 1'b1, 1'b1);
        apply("R9", 4'd0, 8'h99, 8'h00, 4'b0001, 1'b1, 1'b1);
        apply("R9", 4'd0, 8'h09, 8'h01, 4'b0000, 1'b1, 1'b1);
        // R10 decimal subtract
        apply("R10", 4'd1, 8'h46, 8'h12, 4'b0001, 1'b1, 1'b1);
        apply("R10", 4'd1, 8'h12, 8'h21, 4'b0001, 1'b1, 1'b1);
        apply("R10", 4'd1, 8'h40, 8'h13, 4'b0000, 1'b1, 1'b1);
        apply("R10", 4'd1, 8'h00, 8'h00, 4'b0000, 1'b1, 1'b1);
        // R11 decimal not allowed: D ignored
        apply("R11", 4'd0, 8'h58, 8'h46, 4'b0001, 1'b1, 1'b0);
        apply("R11", 4'd1, 8'h12, 8'h21, 4'b0001, 1'b1, 1'b0);
        apply("R11", 4'd0, 8'h09, 8'h01, 4'b0000, 1'b1, 1'b0);
        // R12 / R14 sweep over all defined binary operations
        for (int i = 0; i < 300; i++) begin
            logic [7:0] ra;
            logic [7:0] rb;
            logic [3:0] rf;
            ra = 8'($urandom);
            rb = (i % 7 == 0) ? ra : 8'($urandom);
            rf = 4'($urandom);
            apply((i % 2 == 0) ? "R12" : "R14", 4'(i % 16), ra, rb, rf, 1'b0, 1'($urandom));
        end
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule